// File: doc/BRIEF.md
# Outstanding Line-Miss Tracker with Register Scoreboard

This block keeps a small table of cache-line misses for a non-blocking cache that feeds an in-order pipeline. When a load misses, the block does one of two things. If no entry exists for the missing line and a slot is free, it opens a new entry and issues a single line request toward memory. If the line is already in the table, it merges the load into that entry, and no second request goes out. Each entry records, for every word of its line, which destination register is waiting on that word. The load then leaves the pipeline at once. Its destination register is marked not ready in a per-register ready vector that the block owns.

When memory returns a line, the refill is tagged with the entry number that the request carried. The block then drives one write-back lane for each word of the line that has a waiting register, carrying that register's index and the word's data. It marks those registers ready again and frees the entry. Decode presents up to two source register indices. The block holds decode while any source it uses is still waiting on memory.

A miss is refused with a stall in these cases: the table has no room for a new line, the word already has a waiter, the destination register is already pending, or the line is being refilled in that same cycle.

Top module: `miss_track_table`

## Requirements
- R1: After reset, no entry is in use and every bit of `reg_ready` is 1.
- R2: An accepted miss to a line held by no entry raises `req_valid` in the same cycle, with `req_line` equal to `miss_line` and `req_tag` equal to the lowest-numbered free entry. From the next cycle, `reg_ready[miss_dest]` is 0.
- R3: An accepted miss to a line already held by an entry raises no request and does not stall. It records `miss_dest` against word `miss_word` of that entry, and from the next cycle `reg_ready[miss_dest]` is 0.
- R4: A miss to a new line while all entries are in use asserts `miss_stall`, issues no request and changes no state.
- R5: A miss to a held line whose addressed word already has a waiting register asserts `miss_stall` and changes no state.
- R6: A miss whose `miss_dest` is already not ready asserts `miss_stall` and changes no state.
- R7: A miss to the line of the entry being refilled in the same cycle asserts `miss_stall`.
- R8: A refill to an entry in use drives `wb_en[w]` for each word w that has a waiter. Each such lane carries `wb_reg` lane w equal to that waiter and `wb_data` lane w equal to bits [w*DATA_W +: DATA_W] of `fill_data`, where word 0 sits in the low bits. From the next cycle those registers read ready and the entry is free again.
- R9: A refill whose tag names an entry not in use drives no write-back lane and changes no state.
- R10: `hold_decode` is 1 exactly when `src_a_used` is set and `src_a` is not ready, or when `src_b_used` is set and `src_b` is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed this cycle |
| miss_line | input | LINE_W | Line address of the missing load |
| miss_word | input | log2(WORDS) | Word within the line |
| miss_dest | input | log2(REGS) | Destination register of the load |
| miss_stall | output | 1 | Miss refused; pipeline must hold the load |
| req_valid | output | 1 | New line request toward memory |
| req_line | output | LINE_W | Line address of the request |
| req_tag | output | log2(ENTRIES) | Entry number the refill must carry back |
| fill_valid | input | 1 | A refill line arrives |
| fill_tag | input | log2(ENTRIES) | Entry number of the refill |
| fill_data | input | WORDS*DATA_W | Refill line, word 0 in the low bits |
| wb_en | output | WORDS | Per-word register write enable |
| wb_reg | output | WORDS*log2(REGS) | Per-word destination register index |
| wb_data | output | WORDS*DATA_W | Per-word write data |
| src_a | input | log2(REGS) | First source register at decode |
| src_a_used | input | 1 | First source is read |
| src_b | input | log2(REGS) | Second source register at decode |
| src_b_used | input | 1 | Second source is read |
| hold_decode | output | 1 | Decode must wait for a pending register |
| reg_ready | output | REGS | Per-register ready (full) bit |

## Verification
A directed opening walks one line through allocation, merge, a same-word collision, a pending-destination collision, a decode hold, a refill to a free slot, and a real refill. This sequence tells each stall cause apart from the others, and also tells a merge apart from a second allocation. Further directed steps then fill every slot and aim a miss at a new line, and they collide a miss with the refill of its own line in the same cycle. A long seeded random run follows, drawing line addresses from a narrow pool so that merges, full-table stalls and refills interleave. The pool also includes refill tags that point at idle slots. Every stall, request, write-back lane, decode hold and ready bit is compared each cycle against a bench model built from the requirements.

// File: rtl/mt_pkg.sv
package mt_pkg;
    parameter int MT_ENTRIES = 4;
    parameter int MT_WORDS   = 4;
    parameter int MT_REGS    = 16;
    parameter int MT_LINE_W  = 8;
    parameter int MT_DATA_W  = 16;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mt_line_match.sv
module mt_line_match #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 8,
    parameter int EI_W    = 2
) (
    input  logic [ENTRIES-1:0]             ent_busy,
    input  logic [ENTRIES-1:0][LINE_W-1:0] ent_line,
    input  logic [LINE_W-1:0]              key,
    output logic                           hit_any,
    output logic [EI_W-1:0]                hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = ent_busy[e] && (ent_line[e] == key);
    end

    always_comb begin
        hit_any = |hit_vec;
        hit_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) hit_idx = EI_W'(e);
        end
    end
endmodule

// File: rtl/mt_free_pick.sv
module mt_free_pick #(
    parameter int ENTRIES = 4,
    parameter int EI_W    = 2
) (
    input  logic [ENTRIES-1:0] ent_busy,
    output logic               free_any,
    output logic [EI_W-1:0]    free_idx
);
    always_comb begin
        free_any = ~&ent_busy;
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!ent_busy[e]) free_idx = EI_W'(e);
        end
    end
endmodule

// File: rtl/mt_fill_lanes.sv
module mt_fill_lanes #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int RI_W    = 4,
    parameter int DATA_W  = 16,
    parameter int EI_W    = 2
) (
    input  logic                                     fill_live,
    input  logic [EI_W-1:0]                          fill_tag,
    input  logic [ENTRIES-1:0][WORDS-1:0]            wait_q,
    input  logic [ENTRIES-1:0][WORDS-1:0][RI_W-1:0]  wreg_q,
    input  logic [WORDS*DATA_W-1:0]                  fill_data,
    output logic [WORDS-1:0]                         wb_en,
    output logic [WORDS*RI_W-1:0]                    wb_reg,
    output logic [WORDS*DATA_W-1:0]                  wb_data
);
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign wb_en[w]                    = fill_live && wait_q[fill_tag][w];
        assign wb_reg[w*RI_W +: RI_W]      = wreg_q[fill_tag][w];
        assign wb_data[w*DATA_W +: DATA_W] = fill_data[w*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/miss_track_table.sv
module miss_track_table
    import mt_pkg::*;
#(
    parameter int ENTRIES = MT_ENTRIES,
    parameter int WORDS   = MT_WORDS,
    parameter int REGS    = MT_REGS,
    parameter int LINE_W  = MT_LINE_W,
    parameter int DATA_W  = MT_DATA_W,
    localparam int WI_W   = idx_w(WORDS),
    localparam int RI_W   = idx_w(REGS),
    localparam int EI_W   = idx_w(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    input  logic [LINE_W-1:0]        miss_line,
    input  logic [WI_W-1:0]          miss_word,
    input  logic [RI_W-1:0]          miss_dest,
    output logic                     miss_stall,
    output logic                     req_valid,
    output logic [LINE_W-1:0]        req_line,
    output logic [EI_W-1:0]          req_tag,
    input  logic                     fill_valid,
    input  logic [EI_W-1:0]          fill_tag,
    input  logic [WORDS*DATA_W-1:0]  fill_data,
    output logic [WORDS-1:0]         wb_en,
    output logic [WORDS*RI_W-1:0]    wb_reg,
    output logic [WORDS*DATA_W-1:0]  wb_data,
    input  logic [RI_W-1:0]          src_a,
    input  logic                     src_a_used,
    input  logic [RI_W-1:0]          src_b,
    input  logic                     src_b_used,
    output logic                     hold_decode,
    output logic [REGS-1:0]          reg_ready
);
    typedef struct packed {
        logic [ENTRIES-1:0]                    busy;
        logic [ENTRIES-1:0][LINE_W-1:0]        line;
        logic [ENTRIES-1:0][WORDS-1:0]         wt;
        logic [ENTRIES-1:0][WORDS-1:0][RI_W-1:0] wreg;
        logic [REGS-1:0]                       ready;
    } state_t;

    state_t q, d;

    logic            hit_any;
    logic [EI_W-1:0] hit_idx;
    logic            free_any;
    logic [EI_W-1:0] free_idx;
    logic            fill_live;
    logic            accept;

    mt_line_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .EI_W(EI_W)) u_match (
        .ent_busy (q.busy),
        .ent_line (q.line),
        .key      (miss_line),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx)
    );

    mt_free_pick #(.ENTRIES(ENTRIES), .EI_W(EI_W)) u_free (
        .ent_busy (q.busy),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    assign fill_live = fill_valid && q.busy[fill_tag];

    mt_fill_lanes #(
        .ENTRIES(ENTRIES), .WORDS(WORDS), .RI_W(RI_W), .DATA_W(DATA_W), .EI_W(EI_W)
    ) u_lanes (
        .fill_live (fill_live),
        .fill_tag  (fill_tag),
        .wait_q    (q.wt),
        .wreg_q    (q.wreg),
        .fill_data (fill_data),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .wb_data   (wb_data)
    );

    // Admission decision for the incoming miss.
    always_comb begin
        miss_stall = 1'b0;
        if (miss_valid) begin
            if (!q.ready[miss_dest]) begin
                miss_stall = 1'b1;
            end else if (hit_any) begin
                if (fill_live && (fill_tag == hit_idx)) miss_stall = 1'b1;
                else if (q.wt[hit_idx][miss_word])     miss_stall = 1'b1;
            end else if (!free_any) begin
                miss_stall = 1'b1;
            end
        end
    end

    assign accept      = miss_valid && !miss_stall;
    assign req_valid   = accept && !hit_any;
    assign req_line    = miss_line;
    assign req_tag     = free_idx;
    assign reg_ready   = q.ready;
    assign hold_decode = (src_a_used && !q.ready[src_a]) ||
                         (src_b_used && !q.ready[src_b]);

    // Next-state: refill retirement first, then miss admission.
    always_comb begin
        d = q;
        if (fill_live) begin
            for (int w = 0; w < WORDS; w++) begin
                if (q.wt[fill_tag][w]) d.ready[q.wreg[fill_tag][w]] = 1'b1;
            end
            d.busy[fill_tag] = 1'b0;
            d.wt[fill_tag]   = '0;
        end
        if (accept) begin
            d.ready[miss_dest] = 1'b0;
            if (hit_any) begin
                d.wt[hit_idx][miss_word]   = 1'b1;
                d.wreg[hit_idx][miss_word] = miss_dest;
            end else begin
                d.busy[free_idx]            = 1'b1;
                d.line[free_idx]            = miss_line;
                d.wt[free_idx]              = '0;
                d.wt[free_idx][miss_word]   = 1'b1;
                d.wreg[free_idx][miss_word] = miss_dest;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.ready <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
    import mt_pkg::*;
#(
    parameter int WORDS = MT_WORDS,
    parameter int REGS  = MT_REGS,
    localparam int RI_W = idx_w(REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  miss_valid,
    input logic [RI_W-1:0]       miss_dest,
    input logic                  miss_stall,
    input logic                  req_valid,
    input logic                  fill_valid,
    input logic [WORDS-1:0]      wb_en,
    input logic [WORDS*RI_W-1:0] wb_reg,
    input logic [REGS-1:0]       reg_ready
);
    // R2: a line request only comes from an admitted miss
    assert_req_from_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (miss_valid && !miss_stall));

    // R4: a stall only answers a presented miss
    assert_stall_needs_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stall |-> miss_valid);

    // R3: an admitted miss leaves its destination pending
    assert_dest_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_stall) |=> !reg_ready[$past(miss_dest)]);

    // R9: write-back lanes only fire with a refill
    assert_lanes_need_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_en) |-> fill_valid);

    // R8: a written register reads ready on the next cycle
    assert_lane0_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en[0] |=> reg_ready[$past(wb_reg[RI_W-1:0])]);
endmodule

bind miss_track_table mt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_dest  (miss_dest),
    .miss_stall (miss_stall),
    .req_valid  (req_valid),
    .fill_valid (fill_valid),
    .wb_en      (wb_en),
    .wb_reg     (wb_reg),
    .reg_ready  (reg_ready)
);

// File: tb/tb_miss_track_table.sv
module tb_miss_track_table;
    localparam int E = 4, W = 4, R = 16, LW = 8, DW = 16;
    localparam int WI = 2, RI = 4, EI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 0;
    logic [LW-1:0] miss_line = 0;
    logic [WI-1:0] miss_word = 0;
    logic [RI-1:0] miss_dest = 0;
    logic miss_stall, req_valid;
    logic [LW-1:0] req_line;
    logic [EI-1:0] req_tag;
    logic fill_valid = 0;
    logic [EI-1:0] fill_tag = 0;
    logic [W*DW-1:0] fill_data = 0;
    logic [W-1:0] wb_en;
    logic [W*RI-1:0] wb_reg;
    logic [W*DW-1:0] wb_data;
    logic [RI-1:0] src_a = 0, src_b = 0;
    logic src_a_used = 0, src_b_used = 0;
    logic hold_decode;
    logic [R-1:0] reg_ready;

    always #2.5 clk = ~clk;

    miss_track_table dut (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0;

    // Bench model of the table.
    bit        m_busy [E];
    bit [LW-1:0] m_line [E];
    bit        m_wt   [E][W];
    bit [RI-1:0] m_wreg [E][W];
    bit        m_rdy  [R];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int e = 0; e < E; e++) begin
            m_busy[e] = 0;
            for (int w = 0; w < W; w++) m_wt[e][w] = 0;
        end
        for (int r = 0; r < R; r++) m_rdy[r] = 1;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic check_ready(input string tag);
        for (int r = 0; r < R; r++)
            chk(reg_ready[r] == m_rdy[r], tag, int'(reg_ready[r]), int'(m_rdy[r]));
    endtask

    task automatic op(input bit mv, input int ml, input int mw, input int md,
                      input bit fv, input int ft, input int sa, input bit ua,
                      input int sb, input bit ub);
        bit hit, freea, flive, exp_stall, exp_req, acc;
        int hidx, fidx;
        string cause;
        @(negedge clk);
        miss_valid = mv; miss_line = LW'(ml); miss_word = WI'(mw); miss_dest = RI'(md);
        fill_valid = fv; fill_tag = EI'(ft);
        fill_data = {$urandom, $urandom};
        src_a = RI'(sa); src_a_used = ua; src_b = RI'(sb); src_b_used = ub;
        #1;
        hit = 0; hidx = 0; freea = 0; fidx = 0;
        for (int e = E - 1; e >= 0; e--) begin
            if (m_busy[e] && m_line[e] == LW'(ml)) begin hit = 1; hidx = e; end
            if (!m_busy[e]) begin freea = 1; fidx = e; end
        end
        flive = fv && m_busy[ft];
        exp_stall = 0; cause = hit ? "R3" : "R2";
        if (mv) begin
            if (!m_rdy[md])                        begin exp_stall = 1; cause = "R6"; end
            else if (hit && flive && ft == hidx)   begin exp_stall = 1; cause = "R7"; end
            else if (hit && m_wt[hidx][mw])        begin exp_stall = 1; cause = "R5"; end
            else if (!hit && !freea)               begin exp_stall = 1; cause = "R4"; end
        end
        acc = mv && !exp_stall;
        exp_req = acc && !hit;
        check_ready(flive ? "R8" : "R9");
        chk(miss_stall == exp_stall, cause, int'(miss_stall), int'(exp_stall));
        chk(req_valid == exp_req, hit ? "R3" : "R2", int'(req_valid), int'(exp_req));
        if (exp_req) begin
            chk(req_tag == EI'(fidx), "R2", int'(req_tag), fidx);
            chk(req_line == LW'(ml), "R2", int'(req_line), ml);
        end
        chk(hold_decode == ((ua && !m_rdy[sa]) || (ub && !m_rdy[sb])), "R10",
            int'(hold_decode), int'((ua && !m_rdy[sa]) || (ub && !m_rdy[sb])));
        for (int w = 0; w < W; w++) begin
            bit ee;
            ee = flive && m_wt[ft][w];
            chk(wb_en[w] == ee, flive ? "R8" : "R9", int'(wb_en[w]), int'(ee));
            if (ee) begin
                chk(wb_reg[w*RI +: RI] == m_wreg[ft][w], "R8",
                    int'(wb_reg[w*RI +: RI]), int'(m_wreg[ft][w]));
                chk(wb_data[w*DW +: DW] == fill_data[w*DW +: DW], "R8",
                    int'(wb_data[w*DW +: DW]), int'(fill_data[w*DW +: DW]));
            end
        end
        // Model update, refill before admission.
        if (flive) begin
            for (int w = 0; w < W; w++)
                if (m_wt[ft][w]) begin m_rdy[m_wreg[ft][w]] = 1; m_wt[ft][w] = 0; end
            m_busy[ft] = 0;
        end
        if (acc) begin
            int t;
            t = hit ? hidx : fidx;
            m_rdy[md] = 0;
            if (!hit) begin m_busy[t] = 1; m_line[t] = LW'(ml); end
            m_wt[t][mw] = 1; m_wreg[t][mw] = RI'(md);
        end
    endtask

    task automatic miss(input int l, input int w, input int dst);
        op(1, l, w, dst, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic fill(input int t);
        op(0, 0, 0, 0, 1, t, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check_ready("R1");
        src_a = 4'd9; src_a_used = 1; src_b = 4'd2; src_b_used = 1; #1;
        chk(hold_decode == 0, "R1", int'(hold_decode), 0);

        miss(5, 1, 3);                        // R2 allocate slot 0
        miss(5, 2, 4);                        // R3 merge
        miss(5, 2, 6);                        // R5 word taken
        miss(9, 0, 3);                        // R6 dest pending
        op(0, 0, 0, 0, 0, 0, 3, 1, 4, 0);     // R10 hold on src a
        op(0, 0, 0, 0, 0, 0, 0, 1, 4, 1);     // R10 hold on src b
        fill(1);                              // R9 free slot
        fill(0);                              // R8 write back regs 3 and 4
        miss(7, 0, 1);                        // R2 reuse slot 0
        op(1, 7, 3, 2, 1, 0, 0, 0, 0, 0);     // R7 collision with own refill
        for (int i = 0; i < E; i++) miss(10 + i, i, 5 + i);
        miss(14, 0, 12);                      // R4 table full
        for (int i = 0; i < E; i++) fill(i);

        for (int i = 0; i < 3000; i++) begin
            bit fv;
            fv = ($urandom % 4) == 0;
            op(($urandom % 3) != 0, $urandom % 7, $urandom % W, $urandom % R,
               fv, $urandom % E, $urandom % R, $urandom % 2, $urandom % R, $urandom % 2);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule